// File: doc/BRIEF.md
# BCD Calendar Counter

This block is a timekeeping counter chain that holds seconds, minutes, hours, day of week, date, month and a two-digit year, all in packed BCD except the day of week, which is a small binary count. A one-cycle strobe marks each elapsed second. On each strobe the chain advances one second, and carries ripple upward through the fields. The date wraps at the end of each month, and February gains a 29th day in leap years.

A surrounding controller sets the time with a single load strobe that writes every field at once. A stop input freezes the count so that an idle clock keeps its value. The outputs always show the current registered value of every field.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the fields read 00:00:00, day of week 1, date 01, month 01, year 00.
- R2: Seconds and minutes step in decimal BCD (for example 0x09 to 0x10). At 0x59 a field returns to 0x00 and advances the next field, in the order seconds, minutes, hours.
- R3: Hours run 0x00 to 0x23 in 24-hour form. Stepping past 0x23 returns hours to 0x00 and advances both the date and the day of week.
- R4: Day of week is a 3-bit binary value from 1 to 7. It wraps from 7 to 1 at each midnight, whatever the date.
- R5: The date returns to 0x01 and the month advances after day 30 of months 04, 06, 09 and 11, and after day 31 of the other months except February.
- R6: February ends on day 29 when the BCD year value is divisible by four, year 00 included. In all other years it ends on day 28.
- R7: After 31 December the date becomes 01 January and the year advances by one. Year 0x99 wraps to 0x00.
- R8: While stop is high and no load is present, a tick changes no field.
- R9: A load strobe writes all seven fields from the load inputs in one cycle, even when stop is high. If a tick arrives in the same cycle, the load wins and the tick is lost. Counting then continues from the loaded values.
- R10: A loaded date beyond the current month's last day rolls to 01 of the next month at the next midnight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance strobe |
| stop_i | input | 1 | Freeze counting while high |
| load_i | input | 1 | Parallel load strobe |
| ld_sec_i | input | 8 | Seconds to load, BCD |
| ld_min_i | input | 8 | Minutes to load, BCD |
| ld_hour_i | input | 8 | Hours to load, BCD |
| ld_dow_i | input | 3 | Day of week to load, 1..7 |
| ld_date_i | input | 8 | Date to load, BCD |
| ld_mon_i | input | 8 | Month to load, BCD |
| ld_year_i | input | 8 | Year to load, BCD |
| sec_o | output | 8 | Current seconds |
| min_o | output | 8 | Current minutes |
| hour_o | output | 8 | Current hours |
| dow_o | output | 3 | Current day of week |
| date_o | output | 8 | Current date |
| mon_o | output | 8 | Current month |
| year_o | output | 8 | Current year |

## Verification
A load and a tick can arrive in the same cycle. A tick can also arrive while stop is high, which competes with a load made under stop. The bench raises load and tick together on a value one second before a full carry, 23:59:59 on the last day of a month. If the tick were obeyed, every field would change, so the expected result is exactly the loaded value. A load under stop must also be taken, and the ticks that follow must still be ignored.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BCD_W = 8;
    localparam int DOW_W = 3;

    localparam logic [BCD_W-1:0] SEC_LAST  = 8'h59;
    localparam logic [BCD_W-1:0] MIN_LAST  = 8'h59;
    localparam logic [BCD_W-1:0] HOUR_LAST = 8'h23;
    localparam logic [BCD_W-1:0] MON_LAST  = 8'h12;
    localparam logic [BCD_W-1:0] YEAR_LAST = 8'h99;
    localparam logic [BCD_W-1:0] ZERO_BCD  = 8'h00;
    localparam logic [BCD_W-1:0] ONE_BCD   = 8'h01;
    localparam logic [DOW_W-1:0] DOW_FIRST = 3'd1;
    localparam logic [DOW_W-1:0] DOW_LAST  = 3'd7;

    typedef struct packed {
        logic [BCD_W-1:0] year;
        logic [BCD_W-1:0] mon;
        logic [BCD_W-1:0] date;
        logic [DOW_W-1:0] dow;
        logic [BCD_W-1:0] hour;
        logic [BCD_W-1:0] min;
        logic [BCD_W-1:0] sec;
    } cal_time_t;

endpackage

// File: rtl/cal_bcd_inc.sv
// Packed-BCD field stepper: returns lo_i once the field reaches hi_i,
// otherwise adds one with decimal carry between digits.
module cal_bcd_inc #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    input  logic         en_i,
    output logic [W-1:0] nxt_o,
    output logic         wrap_o
);
    localparam int NDIG = W / 4;

    logic [NDIG:0]  carry;
    logic [W-1:0]   inc_val;

    assign carry[0] = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [3:0] dig;
        assign dig = cur_i[g*4 +: 4];
        always_comb begin
            if (!carry[g]) begin
                inc_val[g*4 +: 4] = dig;
                carry[g+1]        = 1'b0;
            end else if (dig >= 4'd9) begin
                inc_val[g*4 +: 4] = 4'd0;
                carry[g+1]        = 1'b1;
            end else begin
                inc_val[g*4 +: 4] = dig + 4'd1;
                carry[g+1]        = 1'b0;
            end
        end
    end

    always_comb begin
        wrap_o = en_i && (cur_i >= hi_i);
        if (!en_i)
            nxt_o = cur_i;
        else if (wrap_o)
            nxt_o = lo_i;
        else
            nxt_o = inc_val;
    end
endmodule

// File: rtl/cal_month_end.sv
// Last valid date of a month, in BCD, with the divide-by-four leap rule.
module cal_month_end (
    input  logic [7:0] mon_i,
    input  logic [7:0] year_i,
    output logic       leap_o,
    output logic [7:0] last_o
);
    logic [1:0] mod4;

    // (10*tens + units) mod 4 == (2*tens + units) mod 4
    assign mod4   = {year_i[4], 1'b0} + year_i[1:0];
    assign leap_o = (mod4 == 2'd0);

    always_comb begin
        case (mon_i)
            8'h02:                      last_o = leap_o ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
            default:                    last_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             stop_i,
    input  logic             load_i,
    input  logic [BCD_W-1:0] ld_sec_i,
    input  logic [BCD_W-1:0] ld_min_i,
    input  logic [BCD_W-1:0] ld_hour_i,
    input  logic [DOW_W-1:0] ld_dow_i,
    input  logic [BCD_W-1:0] ld_date_i,
    input  logic [BCD_W-1:0] ld_mon_i,
    input  logic [BCD_W-1:0] ld_year_i,
    output logic [BCD_W-1:0] sec_o,
    output logic [BCD_W-1:0] min_o,
    output logic [BCD_W-1:0] hour_o,
    output logic [DOW_W-1:0] dow_o,
    output logic [BCD_W-1:0] date_o,
    output logic [BCD_W-1:0] mon_o,
    output logic [BCD_W-1:0] year_o
);
    cal_time_t state_d, state_q;

    logic             advance;
    logic             sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap, year_wrap;
    logic [BCD_W-1:0] sec_nxt, min_nxt, hour_nxt, date_nxt, mon_nxt, year_nxt;
    logic [BCD_W-1:0] month_last;
    logic             leap_year;

    assign advance = tick_i && !stop_i && !load_i;

    cal_bcd_inc #(.W(BCD_W)) u_sec (
        .cur_i(state_q.sec), .lo_i(ZERO_BCD), .hi_i(SEC_LAST),
        .en_i(advance), .nxt_o(sec_nxt), .wrap_o(sec_wrap));

    cal_bcd_inc #(.W(BCD_W)) u_min (
        .cur_i(state_q.min), .lo_i(ZERO_BCD), .hi_i(MIN_LAST),
        .en_i(sec_wrap), .nxt_o(min_nxt), .wrap_o(min_wrap));

    cal_bcd_inc #(.W(BCD_W)) u_hour (
        .cur_i(state_q.hour), .lo_i(ZERO_BCD), .hi_i(HOUR_LAST),
        .en_i(min_wrap), .nxt_o(hour_nxt), .wrap_o(hour_wrap));

    cal_month_end u_mend (
        .mon_i(state_q.mon), .year_i(state_q.year),
        .leap_o(leap_year), .last_o(month_last));

    cal_bcd_inc #(.W(BCD_W)) u_date (
        .cur_i(state_q.date), .lo_i(ONE_BCD), .hi_i(month_last),
        .en_i(hour_wrap), .nxt_o(date_nxt), .wrap_o(date_wrap));

    cal_bcd_inc #(.W(BCD_W)) u_mon (
        .cur_i(state_q.mon), .lo_i(ONE_BCD), .hi_i(MON_LAST),
        .en_i(date_wrap), .nxt_o(mon_nxt), .wrap_o(mon_wrap));

    cal_bcd_inc #(.W(BCD_W)) u_year (
        .cur_i(state_q.year), .lo_i(ZERO_BCD), .hi_i(YEAR_LAST),
        .en_i(mon_wrap), .nxt_o(year_nxt), .wrap_o(year_wrap));

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.sec  = ld_sec_i;
            state_d.min  = ld_min_i;
            state_d.hour = ld_hour_i;
            state_d.dow  = ld_dow_i;
            state_d.date = ld_date_i;
            state_d.mon  = ld_mon_i;
            state_d.year = ld_year_i;
        end else begin
            state_d.sec  = sec_nxt;
            state_d.min  = min_nxt;
            state_d.hour = hour_nxt;
            state_d.date = date_nxt;
            state_d.mon  = mon_nxt;
            state_d.year = year_nxt;
            if (hour_wrap)
                state_d.dow = (state_q.dow >= DOW_LAST) ? DOW_FIRST
                                                        : state_q.dow + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.sec  <= ZERO_BCD;
            state_q.min  <= ZERO_BCD;
            state_q.hour <= ZERO_BCD;
            state_q.dow  <= DOW_FIRST;
            state_q.date <= ONE_BCD;
            state_q.mon  <= ONE_BCD;
            state_q.year <= ZERO_BCD;
        end else begin
            state_q <= state_d;
        end
    end

    assign sec_o  = state_q.sec;
    assign min_o  = state_q.min;
    assign hour_o = state_q.hour;
    assign dow_o  = state_q.dow;
    assign date_o = state_q.date;
    assign mon_o  = state_q.mon;
    assign year_o = state_q.year;

    // R8
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !load_i) |=> $stable(state_q));

    // R9
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sec_o == $past(ld_sec_i) && min_o == $past(ld_min_i) &&
                    hour_o == $past(ld_hour_i) && dow_o == $past(ld_dow_i) &&
                    date_o == $past(ld_date_i) && mon_o == $past(ld_mon_i) &&
                    year_o == $past(ld_year_i)));

    // R3
    midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23)
        |=> (hour_o == 8'h00 && dow_o != $past(dow_o) && date_o != $past(date_o)));

    // R4
    dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_i) || (dow_o >= DOW_FIRST && dow_o <= DOW_LAST)) ;

    // R7
    year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (year_wrap && year_o == 8'h99) |=> (year_o == 8'h00 && mon_o == 8'h01 && date_o == 8'h01));

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && sec_o == 8'h09) |=> (sec_o == 8'h10 && $stable(min_o)));
endmodule

// File: tb/bcd_calendar_counter_bench.sv
module bcd_calendar_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, stop_i = 1'b0, load_i = 1'b0;
    logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0;
    logic [2:0] ld_dow_i = 3'd1;
    logic [7:0] ld_date_i = 8'h01, ld_mon_i = 8'h01, ld_year_i = '0;
    logic [7:0] sec_o, min_o, hour_o, date_o, mon_o, year_o;
    logic [2:0] dow_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [55:0] v;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    int m_s = 0, m_m = 0, m_h = 0, m_dw = 1, m_dt = 1, m_mo = 1, m_yr = 0;

    always #2 clk = ~clk;

    bcd_calendar_counter u_bcd_calendar_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .stop_i(stop_i), .load_i(load_i),
        .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i),
        .ld_dow_i(ld_dow_i), .ld_date_i(ld_date_i), .ld_mon_i(ld_mon_i),
        .ld_year_i(ld_year_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .mon_o(mon_o), .year_o(year_o));

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int days_in(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] model_vec();
        return {to_bcd(m_yr), to_bcd(m_mo), to_bcd(m_dt), 5'b0, 3'(m_dw),
                to_bcd(m_h), to_bcd(m_m), to_bcd(m_s)};
    endfunction

    task automatic model_tick();
        m_s++;
        if (m_s == 60) begin m_s = 0; m_m++; end
        if (m_m == 60) begin m_m = 0; m_h++; end
        if (m_h == 24) begin
            m_h = 0;
            m_dw = (m_dw == 7) ? 1 : m_dw + 1;
            m_dt++;
            if (m_dt > days_in(m_mo, m_yr)) begin
                m_dt = 1;
                m_mo++;
                if (m_mo == 13) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
            end
        end
    endtask

    // Driver: drives one cycle at the falling edge and queues the expected state.
    task automatic step(bit tk, bit st, bit ld, int hh, int mm, int ss,
                        int dw, int dt, int mo, int yr, string tag);
        @(negedge clk);
        tick_i = tk; stop_i = st; load_i = ld;
        ld_hour_i = to_bcd(hh); ld_min_i = to_bcd(mm); ld_sec_i = to_bcd(ss);
        ld_dow_i = 3'(dw); ld_date_i = to_bcd(dt); ld_mon_i = to_bcd(mo);
        ld_year_i = to_bcd(yr);
        if (ld) begin
            m_h = hh; m_m = mm; m_s = ss; m_dw = dw; m_dt = dt; m_mo = mo; m_yr = yr;
        end else if (tk && !st) begin
            model_tick();
        end
        sb_q.push_back('{v: model_vec(), tag: tag});
    endtask

    task automatic tick1(string tag);
        step(1, 0, 0, 0, 0, 0, 1, 1, 1, 0, tag);
    endtask

    task automatic set(int hh, int mm, int ss, int dw, int dt, int mo, int yr, string tag);
        step(0, 0, 1, hh, mm, ss, dw, dt, mo, yr, tag);
    endtask

    // Monitor: compares one item just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                logic [55:0] got;
                it  = sb_q.pop_front();
                got = {year_o, mon_o, date_o, 5'b0, dow_o, hour_o, min_o, sec_o};
                checks++;
                if (got !== it.v) begin
                    errors++;
                    $display("FAIL %s got=%h expected=%h", it.tag, got, it.v);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state held with no tick
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 0, "R1 reset");
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 0, "R1 idle");
        // R2 free-running seconds across a minute boundary
        for (int i = 0; i < 70; i++) tick1("R2 run");
        set(12, 59, 9, 2, 10, 3, 5, "R9 load");
        tick1("R2 09->10");
        set(12, 59, 59, 2, 10, 3, 5, "R9 load");
        tick1("R2 hour carry");
        // R3 R4 midnight with day of week 7
        set(23, 59, 59, 7, 15, 6, 20, "R9 load");
        tick1("R3 R4 midnight");
        // R5 30 and 31 day months
        set(23, 59, 59, 3, 30, 4, 21, "R9 load");
        tick1("R5 april end");
        set(23, 59, 59, 3, 30, 1, 21, "R9 load");
        tick1("R5 jan 30");
        set(23, 59, 59, 3, 30, 11, 21, "R9 load");
        tick1("R5 nov end");
        // R6 February across several years
        set(23, 59, 59, 1, 28, 2, 24, "R9 load");
        tick1("R6 leap 24");
        set(23, 59, 59, 1, 29, 2, 24, "R9 load");
        tick1("R6 leap end");
        set(23, 59, 59, 1, 28, 2, 23, "R9 load");
        tick1("R6 common 23");
        set(23, 59, 59, 1, 28, 2, 0, "R9 load");
        tick1("R6 year 00");
        set(23, 59, 59, 1, 28, 2, 10, "R9 load");
        tick1("R6 year 10");
        set(23, 59, 59, 1, 28, 2, 12, "R9 load");
        tick1("R6 year 12");
        // R7 year rollovers
        set(23, 59, 59, 5, 31, 12, 99, "R9 load");
        tick1("R7 99->00");
        set(23, 59, 59, 5, 31, 12, 41, "R9 load");
        tick1("R7 41->42");
        // R8 stop freezes
        set(23, 59, 59, 5, 31, 12, 99, "R9 load");
        step(1, 1, 0, 0, 0, 0, 1, 1, 1, 0, "R8 stop tick");
        step(1, 1, 0, 0, 0, 0, 1, 1, 1, 0, "R8 stop tick");
        // R9 load under stop then ticks still frozen
        step(0, 1, 1, 8, 30, 0, 4, 5, 5, 33, "R9 load under stop");
        step(1, 1, 0, 0, 0, 0, 1, 1, 1, 0, "R8 after load");
        tick1("R9 resume");
        // R9 load and tick collide
        set(10, 0, 0, 1, 1, 1, 1, "R9 load");
        step(1, 0, 1, 23, 59, 59, 6, 31, 12, 99, "R9 load beats tick");
        tick1("R9 resume from load");
        // R10 date beyond month end
        set(23, 59, 59, 2, 31, 2, 23, "R9 load");
        tick1("R10 feb 31");
        set(23, 59, 59, 2, 31, 9, 23, "R9 load");
        tick1("R10 sep 31");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule